// File: doc/BRIEF.md
# Timekeeper Alarm Match Unit

This block stores the four alarm fields of a real-time clock (seconds, minutes, hours and day of month) as BCD bytes. It compares them against a BCD time of day that comes in on input ports. An external timebase raises `tick` for one clock cycle once per second, and the compare is evaluated only on that cycle. When the compare succeeds, the block raises a sticky alarm flag and drives a one-cycle interrupt pulse.

Bit 7 of each alarm byte is a repeat mask. The pattern of the four masks sets how often the alarm fires: monthly, daily, hourly, once a minute, or on every tick.

Software writes the alarm bytes through a byte-wide select/data port. Each write is range-checked, and a value outside the legal range for its field is dropped without any indication. The stored bytes can be read back combinationally through a separate read select.

Top module: `rtc_alarm_match`

## Requirements
- R1: After reset all four alarm bytes read 0x00, and `alarm_flag` and `alarm_irq` are low.
- R2: Select code 0 addresses seconds, 1 minutes, 2 hours and 3 date, for both writes and reads. An accepted write stores all 8 bits exactly as written, and `rd_data` returns the stored byte in the same cycle.
- R3: A write to seconds or minutes is accepted only when 10·bits[6:4] + bits[3:0] is at most 59.
- R4: A write to hours is accepted only when 10·bits[5:4] + bits[3:0] is at most 23.
- R5: A write to date is rejected only when 10·bits[5:4] + bits[3:0] equals zero.
- R6: A rejected write leaves the stored byte unchanged.
- R7: With bit 7 clear in all four bytes, the alarm fires on a tick where date and hours match on bits 5:0 and minutes and seconds match on bits 6:0.
- R8: With only the date mask set, the alarm fires on a tick where hours, minutes and seconds match. The date is ignored.
- R9: With only the date and hours masks set, the alarm fires on a tick where minutes and seconds match.
- R10: With only the date, hours and minutes masks set, the alarm fires on a tick where seconds match.
- R11: Every other mask pattern makes the alarm fire on every tick.
- R12: The alarm is evaluated only while `tick` is high. A fire makes `alarm_irq` high for exactly the one cycle that follows the clock edge at which the tick was sampled.
- R13: `alarm_flag` rises together with `alarm_irq` and stays high until `flag_clr` is sampled high. A fire in that same cycle wins over the clear.
- R14: The first tick after reset never fires, whatever the alarm bytes and the time of day.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the selected alarm byte |
| wr_sel | input | 2 | Field selected for writing |
| wr_data | input | 8 | Byte to write |
| rd_sel | input | 2 | Field selected for readback |
| rd_data | output | 8 | Stored byte of the selected field |
| tick | input | 1 | One-cycle pulse once per second |
| tod_sec | input | 7 | Current seconds, BCD |
| tod_min | input | 7 | Current minutes, BCD |
| tod_hour | input | 6 | Current hours, BCD |
| tod_date | input | 6 | Current day of month, BCD |
| flag_clr | input | 1 | Clears the alarm flag |
| alarm_flag | output | 1 | Sticky alarm-occurred flag |
| alarm_irq | output | 1 | One-cycle alarm interrupt pulse |

## Verification
The pulse-width assertion on `alarm_irq` takes for granted that `tick` is never high on two cycles in a row. The bench respects this by raising `tick` for a single cycle and then holding it low for at least one full cycle. The assertions also take for granted that `wr_en` and `tick` are low while reset is applied, which the bench guarantees by driving both low from time zero. Every time-of-day value is driven before the tick edge and held until after that edge. For about half of the random ticks, the time of day is copied from the stored alarm bytes, so that match cases come up often in every mask mode.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
   typedef enum logic [1:0] {
      FLD_SEC  = 2'd0,
      FLD_MIN  = 2'd1,
      FLD_HOUR = 2'd2,
      FLD_DATE = 2'd3
   } alarm_fld_e;

   typedef enum logic [2:0] {
      RATE_MONTH,
      RATE_DAY,
      RATE_HOUR,
      RATE_MINUTE,
      RATE_SECOND
   } alarm_rate_e;

   localparam int unsigned NUM_FIELDS = 4;
   localparam int unsigned BYTE_W     = 8;
   localparam int unsigned MASK_POS   = 7;
endpackage

// File: rtl/rtc_alarm_field.sv
module rtc_alarm_field #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned TENS_W = 3,
   parameter int unsigned LO_LIM = 0,
   parameter int unsigned HI_LIM = 59
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] q
);
   localparam int unsigned VAL_W = 8;

   if (TENS_W < 1 || TENS_W > 3) begin : g_bad_tens
      $error("rtc_alarm_field: TENS_W must be 1..3");
   end
   if (DATA_W < 4 + TENS_W) begin : g_bad_width
      $error("rtc_alarm_field: DATA_W too narrow for the BCD digits");
   end

   logic [TENS_W-1:0] tens;
   logic [3:0]        ones;
   logic [VAL_W-1:0]  val;
   logic              in_range;

   assign tens = wr_data[4 +: TENS_W];
   assign ones = wr_data[3:0];
   assign val  = {{(VAL_W-TENS_W){1'b0}}, tens} * VAL_W'(10) + {{(VAL_W-4){1'b0}}, ones};

   if (LO_LIM == 0) begin : g_lo_zero
      assign in_range = (val <= VAL_W'(HI_LIM));
   end else begin : g_lo_nonzero
      assign in_range = (val >= VAL_W'(LO_LIM)) && (val <= VAL_W'(HI_LIM));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (wr_en && in_range) begin
         q <= wr_data;
      end
   end

   AST_REJECT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !in_range) |=> $stable(q)); // R6
   AST_ACCEPT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && in_range) |=> (q == $past(wr_data))); // R2
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
   import rtc_alarm_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned MS_W   = 7,
   parameter int unsigned HD_W   = 6
) (
   input  logic [DATA_W-1:0] a_sec,
   input  logic [DATA_W-1:0] a_min,
   input  logic [DATA_W-1:0] a_hour,
   input  logic [DATA_W-1:0] a_date,
   input  logic [MS_W-1:0]   t_sec,
   input  logic [MS_W-1:0]   t_min,
   input  logic [HD_W-1:0]   t_hour,
   input  logic [HD_W-1:0]   t_date,
   output alarm_rate_e       rate,
   output logic              hit
);
   if (MS_W >= DATA_W || HD_W >= DATA_W) begin : g_bad_cmp
      $error("rtc_alarm_cmp: value fields must leave room for the mask bit");
   end

   logic [3:0] masks;
   logic eq_s, eq_m, eq_h, eq_d;

   assign masks = {a_date[MASK_POS], a_hour[MASK_POS], a_min[MASK_POS], a_sec[MASK_POS]};
   assign eq_s  = (a_sec[MS_W-1:0]  == t_sec);
   assign eq_m  = (a_min[MS_W-1:0]  == t_min);
   assign eq_h  = (a_hour[HD_W-1:0] == t_hour);
   assign eq_d  = (a_date[HD_W-1:0] == t_date);

   always_comb begin
      case (masks)
         4'b0000: rate = RATE_MONTH;
         4'b1000: rate = RATE_DAY;
         4'b1100: rate = RATE_HOUR;
         4'b1110: rate = RATE_MINUTE;
         default: rate = RATE_SECOND;
      endcase
   end

   always_comb begin
      case (rate)
         RATE_MONTH:  hit = eq_d && eq_h && eq_m && eq_s;
         RATE_DAY:    hit = eq_h && eq_m && eq_s;
         RATE_HOUR:   hit = eq_m && eq_s;
         RATE_MINUTE: hit = eq_s;
         default:     hit = 1'b1;
      endcase
   end
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
   import rtc_alarm_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned SEL_W  = 2,
   parameter int unsigned MS_W   = 7,
   parameter int unsigned HD_W   = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SEL_W-1:0]  wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [SEL_W-1:0]  rd_sel,
   output logic [DATA_W-1:0] rd_data,
   input  logic              tick,
   input  logic [MS_W-1:0]   tod_sec,
   input  logic [MS_W-1:0]   tod_min,
   input  logic [HD_W-1:0]   tod_hour,
   input  logic [HD_W-1:0]   tod_date,
   input  logic              flag_clr,
   output logic              alarm_flag,
   output logic              alarm_irq
);
   localparam int unsigned NF = 1 << SEL_W;

   if (NF != NUM_FIELDS) begin : g_bad_sel
      $error("rtc_alarm_match: SEL_W must address exactly four fields");
   end
   if (DATA_W != BYTE_W) begin : g_bad_data
      $error("rtc_alarm_match: DATA_W must be one byte");
   end

   logic [NF-1:0][DATA_W-1:0] areg;

   for (genvar i = 0; i < NF; i++) begin : g_fld
      localparam int unsigned TW = (i < 2) ? 3 : 2;
      localparam int unsigned LO = (i == int'(FLD_DATE)) ? 1 : 0;
      localparam int unsigned HI = (i < 2) ? 59 : ((i == int'(FLD_HOUR)) ? 23 : 255);
      logic we;
      assign we = wr_en && (wr_sel == SEL_W'(i));
      rtc_alarm_field #(
         .DATA_W (DATA_W),
         .TENS_W (TW),
         .LO_LIM (LO),
         .HI_LIM (HI)
      ) u_fld (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (we),
         .wr_data (wr_data),
         .q       (areg[i])
      );
   end

   assign rd_data = areg[rd_sel];

   alarm_rate_e rate;
   logic        hit;

   rtc_alarm_cmp #(
      .DATA_W (DATA_W),
      .MS_W   (MS_W),
      .HD_W   (HD_W)
   ) u_cmp (
      .a_sec  (areg[FLD_SEC]),
      .a_min  (areg[FLD_MIN]),
      .a_hour (areg[FLD_HOUR]),
      .a_date (areg[FLD_DATE]),
      .t_sec  (tod_sec),
      .t_min  (tod_min),
      .t_hour (tod_hour),
      .t_date (tod_date),
      .rate   (rate),
      .hit    (hit)
   );

   logic armed_q;
   logic fire;

   assign fire = tick && armed_q && hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q    <= 1'b0;
         alarm_irq  <= 1'b0;
         alarm_flag <= 1'b0;
      end else begin
         if (tick) armed_q <= 1'b1;
         alarm_irq  <= fire;
         alarm_flag <= fire | (alarm_flag & ~flag_clr);
      end
   end

   AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_irq |=> !alarm_irq); // R12
   AST_IRQ_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> !alarm_irq); // R12
   AST_IRQ_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_irq |-> alarm_flag); // R13
   AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (alarm_flag && !flag_clr && !tick) |=> alarm_flag); // R13
   AST_FIRST_TICK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !armed_q) |=> !alarm_irq); // R14
   AST_SECOND_RATE: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && armed_q && rate == RATE_SECOND) |=> alarm_irq); // R11
endmodule

// File: tb/rtc_alarm_match_tb_top.sv
module rtc_alarm_match_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_sel = '0;
   logic [7:0] wr_data = '0;
   logic [1:0] rd_sel = '0;
   logic [7:0] rd_data;
   logic       tick = 1'b0;
   logic [6:0] tod_sec = '0;
   logic [6:0] tod_min = '0;
   logic [5:0] tod_hour = '0;
   logic [5:0] tod_date = '0;
   logic       flag_clr = 1'b0;
   logic       alarm_flag;
   logic       alarm_irq;

   always #10 clk = ~clk;

   rtc_alarm_match dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .rd_sel(rd_sel), .rd_data(rd_data), .tick(tick), .tod_sec(tod_sec),
      .tod_min(tod_min), .tod_hour(tod_hour), .tod_date(tod_date),
      .flag_clr(flag_clr), .alarm_flag(alarm_flag), .alarm_irq(alarm_irq)
   );

   int  checks = 0;
   int  errors = 0;
   bit  done = 0;
   logic [7:0] mdl [4];
   bit  armed_m = 0;
   bit  flag_m = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic bit accept(input int sel, input logic [7:0] d);
      int v;
      v = ((sel < 2) ? int'(d[6:4]) : int'(d[5:4])) * 10 + int'(d[3:0]);
      case (sel)
         0, 1:    return v <= 59;
         2:       return v <= 23;
         default: return v != 0;
      endcase
   endfunction

   function automatic bit exp_hit(input logic [6:0] s, input logic [6:0] m,
                                  input logic [5:0] h, input logic [5:0] d);
      bit es, em, eh, ed;
      logic [3:0] mk;
      es = (mdl[0][6:0] == s);
      em = (mdl[1][6:0] == m);
      eh = (mdl[2][5:0] == h);
      ed = (mdl[3][5:0] == d);
      mk = {mdl[3][7], mdl[2][7], mdl[1][7], mdl[0][7]};
      if (mk == 4'b0000) return ed && eh && em && es;
      if (mk == 4'b1000) return eh && em && es;
      if (mk == 4'b1100) return em && es;
      if (mk == 4'b1110) return es;
      return 1'b1;
   endfunction

   task automatic wr(input int sel, input logic [7:0] d, input string tag);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = 2'(sel); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      if (accept(sel, d)) mdl[sel] = d;
      rd_sel = 2'(sel);
      #1;
      chk(tag, rd_data, mdl[sel]);
   endtask

   task automatic tick_at(input logic [6:0] s, input logic [6:0] m,
                          input logic [5:0] h, input logic [5:0] d, input string tag);
      bit e;
      @(negedge clk);
      tod_sec = s; tod_min = m; tod_hour = h; tod_date = d;
      tick = 1'b1;
      e = armed_m && exp_hit(s, m, h, d);
      armed_m = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      if (e) flag_m = 1'b1;
      chk({tag, " irq"}, alarm_irq, e);
      chk({tag, " flag"}, alarm_flag, flag_m);
      @(negedge clk);
      chk("R12 pulse ends", alarm_irq, 1'b0);
   endtask

   task automatic clear_flag();
      @(negedge clk);
      flag_clr = 1'b1;
      @(negedge clk);
      flag_clr = 1'b0;
      flag_m = 1'b0;
      chk("R13 clear", alarm_flag, 1'b0);
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int unsigned seed;
      seed = 32'd1234;
      for (int i = 0; i < 4; i++) mdl[i] = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 irq", alarm_irq, 1'b0);
      chk("R1 flag", alarm_flag, 1'b0);
      for (int i = 0; i < 4; i++) begin
         rd_sel = 2'(i); #1;
         chk("R1 reg", rd_data, 8'h00);
      end

      tick_at(7'h00, 7'h00, 6'h00, 6'h00, "R14");
      tick_at(7'h00, 7'h00, 6'h00, 6'h00, "R7 match");
      tick_at(7'h00, 7'h00, 6'h00, 6'h01, "R7 date differs");
      clear_flag();

      wr(0, 8'h59, "R3 sec 59");
      wr(0, 8'h60, "R6 sec 60");
      wr(1, 8'h5A, "R3 min 60");
      wr(1, 8'h00, "R3 min 0");
      wr(2, 8'h23, "R4 hour 23");
      wr(2, 8'h24, "R4 hour 24");
      wr(2, 8'h52, "R2 hour bit6 kept");
      wr(3, 8'h00, "R5 date 0");
      wr(3, 8'h80, "R5 masked date 0");
      wr(3, 8'h31, "R5 date 31");

      wr(3, 8'h81, "R8 setup");
      wr(2, 8'h12, "R8 setup");
      wr(1, 8'h34, "R8 setup");
      wr(0, 8'h56, "R8 setup");
      tick_at(7'h56, 7'h34, 6'h12, 6'h05, "R8 match");
      tick_at(7'h56, 7'h34, 6'h13, 6'h05, "R8 hour differs");
      clear_flag();
      wr(2, 8'h92, "R9 setup");
      tick_at(7'h56, 7'h34, 6'h07, 6'h09, "R9 match");
      tick_at(7'h56, 7'h35, 6'h12, 6'h01, "R9 min differs");
      wr(1, 8'hB4, "R10 setup");
      tick_at(7'h56, 7'h11, 6'h03, 6'h02, "R10 match");
      tick_at(7'h57, 7'h34, 6'h12, 6'h01, "R10 sec differs");
      wr(3, 8'h01, "R11 setup");
      tick_at(7'h01, 7'h02, 6'h03, 6'h04, "R11 every tick");
      clear_flag();

      for (int n = 0; n < 400; n++) begin
         int op;
         op = int'($urandom(seed) % 3);
         seed = seed + 32'd7919;
         if (op == 0) begin
            wr(int'($urandom % 4), 8'($urandom), "R2 random write");
         end else if (op == 1) begin
            if ($urandom % 2 == 0)
               tick_at(mdl[0][6:0], mdl[1][6:0], mdl[2][5:0], mdl[3][5:0], "R7 random match");
            else
               tick_at(7'($urandom), 7'($urandom), 6'($urandom), 6'($urandom), "R11 random tick");
         end else begin
            clear_flag();
         end
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule